// File: doc/BRIEF.md
# Multi-channel PWM timer bank

A bank of independent pulse-width timers sharing one simple register bus. Each channel owns a 16-bit up-counter and two 16-bit compare values: a duty threshold and a period limit. Within a period the pin rests at the channel's idle level while the counter is below the duty threshold. It takes the opposite level from the threshold until the counter hits the period limit, and then the counter wraps. A per-channel idle-level bit sets the polarity. An output-enable bit gates the pin, and a stop-style bit chooses whether stopping or gating takes effect at once or only at the end of the running period.

Software starts and stops counters through two shared strobe registers, one that sets and one that clears, each bit addressing one channel. The counter can also be written directly, for example to zero it before reprogramming. Duty and period writes are held in the compare logic's shadow copy until the next wrap, so a running waveform never sees a half-updated pair. Every channel drives one pin and one running flag. The read port is combinational and returns the written values.

Top module: `pwm_bank`

## Requirements
- R1: After reset every counter is stopped and reads 0, every control field reads 0, every running flag is 0 and every pin is low.
- R2: With output enabled and duty D not above period P, the pin is at the idle level while count < D, at the opposite level for D <= count < P, and at the idle level at count = P. The count steps by one per clock and goes from P to 0, so a period lasts P+1 clocks.
- R3: Control bit 1 (idle-high) set makes the idle level high and inverts the whole waveform of R2.
- R4: When duty exceeds period the pin stays at the idle level for the whole period.
- R5: A write to address 0 (start) with bit n set starts counter n on the next clock, and a write to address 1 (stop) with bit n set requests a stop of counter n. Zero bits change nothing, and no channel starts without a start write.
- R6: Writing a channel's counter field loads that value on the next clock, whether the channel runs or not. A stopped counter holds its value.
- R7: With control bit 2 (abrupt) set, clearing control bit 0 (output enable) drives the pin to the idle level on the next clock while the counter keeps running.
- R8: With the abrupt bit set, a stop request clears the running flag on the next clock, the pin goes to the idle level and the counter freezes.
- R9: With the abrupt bit clear, a stop request lets the current period finish. The channel keeps running to count = P, then halts with the counter at 0 and the pin at the idle level.
- R10: With the abrupt bit clear, clearing output enable while running leaves the waveform intact to the end of the period, and the pin is at the idle level from the next period on.
- R11: Duty and period fields read back the last written value. A write while running takes effect in the compare only after the next wrap.

Register map (word addresses): 0 start strobes, 1 stop strobes, 2 running flags (0–2 all read the running flags). Channel n occupies 4+4n..7+4n: +0 control (bit 0 output enable, bit 1 idle-high, bit 2 abrupt), +1 duty, +2 period, +3 counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters advance one step per cycle while running |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | AW (8) | Write word address |
| wr_data | input | DW (16) | Write data |
| rd_addr | input | AW (8) | Read word address |
| rd_data | output | DW (16) | Combinational read data |
| pwm_out | output | NCH (8) | One pulse-width output per channel |
| run_stat | output | NCH (8) | Running flag per channel |

## Verification
The assertions check on every cycle that all channels come out of reset stopped with low pins, that a running flag rises only after a start strobe for that channel and always follows one, that an abrupt stop drops the flag on the next clock, and that any stopped channel drives its idle level. Only the bench scenarios can show the waveform shape against the live counter, the inversion by the idle-high bit, the duty-above-period case, the deferred end of a graceful stop or gate-off, counter loading, and the shadowing of duty changes until the wrap.

// File: rtl/pwm_pkg.sv
// Shared definitions for the PWM timer bank: register word map and the
// per-channel control field layout. Assumes a stride of four words per channel.
package pwm_pkg;

    // Global strobe / status words
    localparam int unsigned ADDR_START = 0;
    localparam int unsigned ADDR_STOP  = 1;
    localparam int unsigned ADDR_RUN   = 2;

    // Field offsets inside a channel's four-word window (window k+1 = channel k)
    localparam logic [1:0] FLD_CTRL = 2'd0;
    localparam logic [1:0] FLD_DUTY = 2'd1;
    localparam logic [1:0] FLD_PER  = 2'd2;
    localparam logic [1:0] FLD_CNT  = 2'd3;

    // Control field: bit 0 output enable, bit 1 idle-high, bit 2 abrupt stop
    typedef struct packed {
        logic abrupt;
        logic idle_high;
        logic out_en;
    } chan_ctrl_t;

    localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/pwm_wr_decode.sv
// Write-side address decoder. Turns one bus write into per-channel field
// strobes plus start/stop bit vectors. Assumes AW is wide enough to hold
// 4 + 4*NCH words and that NCH does not exceed DW.
module pwm_wr_decode
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 16
) (
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [NCH-1:0] wr_bits,
    output logic [NCH-1:0] start_stb,
    output logic [NCH-1:0] stop_stb,
    output logic [NCH-1:0] ctrl_we,
    output logic [NCH-1:0] duty_we,
    output logic [NCH-1:0] per_we,
    output logic [NCH-1:0] cnt_we
);
    localparam int unsigned WW = AW - 2;

    logic [WW-1:0] win;
    logic [1:0]    fld;

    assign win = wr_addr[AW-1:2];
    assign fld = wr_addr[1:0];

    // Global strobe words: only the set bits of the data act
    always_comb begin
        start_stb = (wr_en && wr_addr == AW'(ADDR_START)) ? wr_bits : '0;
        stop_stb  = (wr_en && wr_addr == AW'(ADDR_STOP))  ? wr_bits : '0;
    end

    // Per-channel field write enables
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic hit;
        assign hit        = wr_en && (win == WW'(i + 1));
        assign ctrl_we[i] = hit && (fld == FLD_CTRL);
        assign duty_we[i] = hit && (fld == FLD_DUTY);
        assign per_we[i]  = hit && (fld == FLD_PER);
        assign cnt_we[i]  = hit && (fld == FLD_CNT);
    end

endmodule

// File: rtl/pwm_rd_mux.sv
// Combinational read-back multiplexer. Returns the running flags for the
// global words and the written control/duty/period or the live counter for
// channel windows; unmapped words read zero. Assumes NCH <= DW.
module pwm_rd_mux
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 16
) (
    input  logic [AW-1:0]              rd_addr,
    input  logic [NCH-1:0]             run,
    input  logic [NCH-1:0][CTRL_W-1:0] ctrl,
    input  logic [NCH-1:0][DW-1:0]     duty,
    input  logic [NCH-1:0][DW-1:0]     per,
    input  logic [NCH-1:0][DW-1:0]     cnt,
    output logic [DW-1:0]              rd_data
);
    localparam int unsigned WW = AW - 2;

    logic [WW-1:0] win;
    logic [1:0]    fld;

    assign win = rd_addr[AW-1:2];
    assign fld = rd_addr[1:0];

    // Select the addressed word
    always_comb begin
        rd_data = '0;
        if (win == '0) begin
            if (fld != 2'd3) rd_data[NCH-1:0] = run;
        end
        for (int i = 0; i < NCH; i++) begin
            if (win == WW'(i + 1)) begin
                case (fld)
                    FLD_CTRL: rd_data[CTRL_W-1:0] = ctrl[i];
                    FLD_DUTY: rd_data = duty[i];
                    FLD_PER:  rd_data = per[i];
                    default:  rd_data = cnt[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_channel.sv
// One timer channel: up-counter, shadowed duty/period compare, stop and
// gate handling, pin level. Assumes start and stop never strobe in the
// same cycle (they come from different bus words).
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              ctrl_we,
    input  logic              duty_we,
    input  logic              per_we,
    input  logic              cnt_we,
    input  logic [CW-1:0]     wdata,
    output chan_ctrl_t        ctrl_q,
    output logic [CW-1:0]     duty_q,
    output logic [CW-1:0]     per_q,
    output logic [CW-1:0]     cnt_q,
    output logic              run_q,
    output logic              pin
);
    chan_ctrl_t    ctrl_d;
    logic [CW-1:0] duty_sh;
    logic [CW-1:0] per_sh;
    logic          stop_pend;
    logic          gate_hold;
    logic          wrap;
    logic          in_pulse;
    logic          oe_fall;

    assign ctrl_d  = chan_ctrl_t'(wdata[CTRL_W-1:0]);
    assign wrap    = run_q && (cnt_q == per_sh);
    assign oe_fall = ctrl_we && ctrl_q.out_en && !ctrl_d.out_en;

    // Software-visible fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            duty_q <= '0;
            per_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_d;
            if (duty_we) duty_q <= wdata;
            if (per_we)  per_q  <= wdata;
        end
    end

    // Compare shadow: follows the fields while stopped, reloads at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_sh <= '0;
            per_sh  <= '0;
        end else if (!run_q || wrap) begin
            duty_sh <= duty_q;
            per_sh  <= per_q;
        end
    end

    // Run state with abrupt or end-of-period stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            stop_pend <= 1'b0;
        end else if (start) begin
            run_q     <= 1'b1;
            stop_pend <= 1'b0;
        end else if (stop && run_q) begin
            if (ctrl_q.abrupt) begin
                run_q     <= 1'b0;
                stop_pend <= 1'b0;
            end else begin
                stop_pend <= 1'b1;
            end
        end else if (wrap && stop_pend) begin
            run_q     <= 1'b0;
            stop_pend <= 1'b0;
        end
    end

    // Counter: direct load wins, else count and wrap while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
        end else if (run_q) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // Keep the pin gated on until the period ends after a graceful gate-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hold <= 1'b0;
        end else if (!run_q || wrap) begin
            gate_hold <= 1'b0;
        end else if (oe_fall && !ctrl_d.abrupt) begin
            gate_hold <= 1'b1;
        end
    end

    // Pin level: idle level flipped inside the active window
    assign in_pulse = (cnt_q >= duty_sh) && (cnt_q < per_sh);
    assign pin      = ctrl_q.idle_high ^
                      (run_q && in_pulse && (ctrl_q.out_en || gate_hold));

endmodule

// File: rtl/pwm_bank_chk.sv
// Property checker for the PWM timer bank, attached to every pwm_bank.
module pwm_bank_chk
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [NCH-1:0] run_stat,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] idle_lvl,
    input logic [NCH-1:0] abrupt_sel
);

    // R1: leaving reset, everything is stopped and low
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (run_stat == '0 && pwm_out == '0));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // R5: a running flag only rises after a start strobe for this channel
        assert_start_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_stat[n]) |->
                $past(wr_en && wr_addr == AW'(ADDR_START) && wr_data[n]));

        // R5: a start strobe always sets the running flag
        assert_start_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(ADDR_START) && wr_data[n]) |=> run_stat[n]);

        // R8: abrupt stop drops the running flag on the next clock
        assert_abrupt_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(ADDR_STOP) && wr_data[n] && abrupt_sel[n])
                |=> !run_stat[n]);

        // R8/R9: a stopped channel drives its idle level
        assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !run_stat[n] |-> (pwm_out[n] == idle_lvl[n]));
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .run_stat   (run_stat),
    .pwm_out    (pwm_out),
    .idle_lvl   (idle_vec),
    .abrupt_sel (abrupt_vec)
);

// File: rtl/pwm_bank.sv
// Top of the PWM timer bank: write decoder, NCH timer channels and the
// read-back multiplexer. Counters tick on every clock while running.
// Assumes NCH <= DW and 4 + 4*NCH <= 2**AW.
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] run_stat
);
    logic [NCH-1:0]             start_stb, stop_stb;
    logic [NCH-1:0]             ctrl_we, duty_we, per_we, cnt_we;
    logic [NCH-1:0][CTRL_W-1:0] ctrl_arr;
    logic [NCH-1:0][DW-1:0]     duty_arr, per_arr, cnt_arr;
    logic [NCH-1:0]             idle_vec, abrupt_vec;

    pwm_wr_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_bits   (wr_data[NCH-1:0]),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .ctrl_we   (ctrl_we),
        .duty_we   (duty_we),
        .per_we    (per_we),
        .cnt_we    (cnt_we)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        chan_ctrl_t c_q;

        pwm_channel #(.CW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start_stb[i]),
            .stop    (stop_stb[i]),
            .ctrl_we (ctrl_we[i]),
            .duty_we (duty_we[i]),
            .per_we  (per_we[i]),
            .cnt_we  (cnt_we[i]),
            .wdata   (wr_data),
            .ctrl_q  (c_q),
            .duty_q  (duty_arr[i]),
            .per_q   (per_arr[i]),
            .cnt_q   (cnt_arr[i]),
            .run_q   (run_stat[i]),
            .pin     (pwm_out[i])
        );

        assign ctrl_arr[i]   = c_q;
        assign idle_vec[i]   = c_q.idle_high;
        assign abrupt_vec[i] = c_q.abrupt;
    end

    pwm_rd_mux #(.NCH(NCH), .AW(AW), .DW(DW)) u_rd (
        .rd_addr (rd_addr),
        .run     (run_stat),
        .ctrl    (ctrl_arr),
        .duty    (duty_arr),
        .per     (per_arr),
        .cnt     (cnt_arr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
    localparam int NCH = 8;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int A_START = 0, A_STOP = 1, A_RUN = 2;
    localparam int F_CTRL = 0, F_DUTY = 1, F_PER = 2, F_CNT = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [DW-1:0]  rd_data;
    logic [NCH-1:0] pwm_out, run_stat;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .run_stat(run_stat)
    );

    function automatic int ca(int ch, int fld);
        return 4 + 4 * ch + fld;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns after the next falling edge
    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        rd_addr = AW'(a);
        #0.2;
        v = int'(rd_data);
    endtask

    task automatic wait_cnt(int ch, int val);
        int c;
        for (int k = 0; k < 100; k++) begin
            rd(ca(ch, F_CNT), c);
            if (c == val) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int v;
        rd(A_RUN, v);            chk(v == 0, "R1 run flags", v, 0);
        chk(pwm_out == 0, "R1 pins low", int'(pwm_out), 0);
        rd(ca(3, F_CNT), v);     chk(v == 0, "R1 counter", v, 0);
        rd(ca(5, F_CTRL), v);    chk(v == 0, "R1 control", v, 0);
    endtask

    task automatic t_wave;
        int c, prev;
        wr(ca(0, F_CTRL), 1); wr(ca(0, F_DUTY), 3); wr(ca(0, F_PER), 7);
        wr(A_START, 1);
        chk(run_stat == 8'h01, "R5 only ch0 started", int'(run_stat), 1);
        prev = -1;
        for (int k = 0; k < 24; k++) begin
            rd(ca(0, F_CNT), c);
            chk(pwm_out[0] == (c >= 3 && c < 7), "R2 waveform", int'(pwm_out[0]),
                int'(c >= 3 && c < 7));
            if (prev == 7) chk(c == 0, "R2 wrap", c, 0);
            else if (prev >= 0) chk(c == prev + 1, "R2 step", c, prev + 1);
            prev = c;
            @(negedge clk);
        end
    endtask

    task automatic t_polarity;
        int c;
        wr(ca(1, F_CTRL), 3); wr(ca(1, F_DUTY), 2); wr(ca(1, F_PER), 5);
        wr(A_START, 2);
        chk(run_stat == 8'h03, "R5 ch1 added", int'(run_stat), 3);
        for (int k = 0; k < 12; k++) begin
            rd(ca(1, F_CNT), c);
            chk(pwm_out[1] == !(c >= 2 && c < 5), "R3 inverted", int'(pwm_out[1]),
                int'(!(c >= 2 && c < 5)));
            @(negedge clk);
        end
    endtask

    task automatic t_duty_over;
        int c;
        wr(ca(2, F_CTRL), 1); wr(ca(2, F_DUTY), 9); wr(ca(2, F_PER), 5);
        wr(A_START, 4);
        for (int k = 0; k < 14; k++) begin
            rd(ca(2, F_CNT), c);
            chk(pwm_out[2] == 1'b0, "R4 idle all period", int'(pwm_out[2]), 0);
            chk(c <= 5, "R4 counter bounded", c, 5);
            @(negedge clk);
        end
    endtask

    task automatic t_strobes;
        int s0, s1;
        rd(A_RUN, s0);
        wr(A_START, 0); wr(A_STOP, 0);
        rd(A_RUN, s1); chk(s1 == s0, "R5 zero bits ignored", s1, s0);
        wr(A_STOP, 2);
        repeat (8) @(negedge clk);
        rd(A_RUN, s1); chk(s1 == 5, "R5 only ch1 stopped", s1, 5);
        chk(pwm_out[1] == 1'b1, "R9 stopped at idle high", int'(pwm_out[1]), 1);
    endtask

    task automatic t_count_load;
        int c;
        wr(ca(0, F_CNT), 5);
        rd(ca(0, F_CNT), c); chk(c == 5, "R6 load running", c, 5);
        @(negedge clk);
        rd(ca(0, F_CNT), c); chk(c == 6, "R6 counts on", c, 6);
        wr(ca(7, F_CNT), 16'h1234);
        rd(ca(7, F_CNT), c); chk(c == 16'h1234, "R6 load stopped", c, 16'h1234);
        @(negedge clk);
        rd(ca(7, F_CNT), c); chk(c == 16'h1234, "R6 stopped holds", c, 16'h1234);
    endtask

    task automatic t_abrupt;
        int c1, c2;
        wr(ca(3, F_CTRL), 5); wr(ca(3, F_DUTY), 0); wr(ca(3, F_PER), 9);
        wr(A_START, 8);
        wait_cnt(3, 2);
        chk(pwm_out[3] == 1'b1, "R7 active before gate", int'(pwm_out[3]), 1);
        wr(ca(3, F_CTRL), 4);
        chk(pwm_out[3] == 1'b0, "R7 gated at once", int'(pwm_out[3]), 0);
        chk(run_stat[3] == 1'b1, "R7 still running", int'(run_stat[3]), 1);
        rd(ca(3, F_CNT), c1); @(negedge clk); rd(ca(3, F_CNT), c2);
        chk(c2 == ((c1 == 9) ? 0 : c1 + 1), "R7 counter runs", c2, (c1 == 9) ? 0 : c1 + 1);
        wr(ca(3, F_CTRL), 5);
        wait_cnt(3, 4);
        wr(A_STOP, 8);
        chk(run_stat[3] == 1'b0, "R8 flag drops", int'(run_stat[3]), 0);
        chk(pwm_out[3] == 1'b0, "R8 pin idle", int'(pwm_out[3]), 0);
        rd(ca(3, F_CNT), c1); @(negedge clk); rd(ca(3, F_CNT), c2);
        chk(c2 == c1, "R8 counter frozen", c2, c1);
    endtask

    task automatic t_graceful_stop;
        int c, n;
        wr(ca(4, F_CTRL), 1); wr(ca(4, F_DUTY), 0); wr(ca(4, F_PER), 9);
        wr(A_START, 16);
        wait_cnt(4, 2);
        wr(A_STOP, 16);
        chk(run_stat[4] == 1'b1, "R9 runs after stop", int'(run_stat[4]), 1);
        n = 0;
        while (run_stat[4] && n < 20) begin
            rd(ca(4, F_CNT), c);
            chk(pwm_out[4] == (c < 9), "R9 period completes", int'(pwm_out[4]), int'(c < 9));
            @(negedge clk);
            n++;
        end
        chk(n == 7, "R9 halts after wrap", n, 7);
        rd(ca(4, F_CNT), c); chk(c == 0, "R9 halts at zero", c, 0);
        chk(pwm_out[4] == 1'b0, "R9 idle after halt", int'(pwm_out[4]), 0);
    endtask

    task automatic t_graceful_gate;
        int c;
        wr(ca(5, F_CTRL), 1); wr(ca(5, F_DUTY), 0); wr(ca(5, F_PER), 9);
        wr(A_START, 32);
        wait_cnt(5, 3);
        wr(ca(5, F_CTRL), 0);
        chk(pwm_out[5] == 1'b1, "R10 pulse kept", int'(pwm_out[5]), 1);
        for (int k = 0; k < 12; k++) begin
            rd(ca(5, F_CNT), c);
            if (c == 0) break;
            chk(pwm_out[5] == (c < 9), "R10 period finishes", int'(pwm_out[5]), int'(c < 9));
            @(negedge clk);
        end
        chk(run_stat[5] == 1'b1, "R10 keeps counting", int'(run_stat[5]), 1);
        chk(pwm_out[5] == 1'b0, "R10 gated next period", int'(pwm_out[5]), 0);
        @(negedge clk);
        chk(pwm_out[5] == 1'b0, "R10 stays gated", int'(pwm_out[5]), 0);
    endtask

    task automatic t_shadow;
        int c, d, v;
        wr(ca(6, F_CTRL), 1); wr(ca(6, F_DUTY), 2); wr(ca(6, F_PER), 5);
        wr(A_START, 64);
        wait_cnt(6, 1);
        wr(ca(6, F_DUTY), 4);
        rd(ca(6, F_DUTY), v); chk(v == 4, "R11 readback", v, 4);
        rd(ca(6, F_PER), v);  chk(v == 5, "R11 period readback", v, 5);
        d = 2;
        for (int k = 0; k < 14; k++) begin
            rd(ca(6, F_CNT), c);
            if (c == 0) d = 4;
            chk(pwm_out[6] == (c >= d && c < 5), "R11 duty at wrap", int'(pwm_out[6]),
                int'(c >= d && c < 5));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wave();
        t_polarity();
        t_duty_over();
        t_strobes();
        t_count_load();
        t_abrupt();
        t_graceful_stop();
        t_graceful_gate();
        t_shadow();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule